// File: doc/BRIEF.md
# Debug Chain Frame Decoder

This block sits behind a test access port and interprets the serial data-register frames addressed to an on-chip debug unit. While the instruction register holds the debug instruction, every frame starts with a flag bit. A flag of 1 marks a target-selection frame and a flag of 0 marks a command frame. The flag is followed by a 4-bit target ID or command code and then a 32-bit checksum that protects those first five bits. Both fields are sent most significant bit first.

As the frame header and its checksum arrive, the block checks them. It then shifts back a response on the same scan: 37 zero bits, a 4-bit status and a fresh checksum over that status. When the scan reaches the update step, a good selection frame changes the stored target. A good command frame is handed to the command handler as a one-cycle strobe carrying its code. Bus-access errors reported by the access logic are held until a response carries them out.

Top module: `dbg_frame_decoder`

## Requirements
- R1: Unless `irValue` equals `DEBUG_IR` (default 4'b1000), capture, shift and update have no effect: `tdo` stays 0, `selModule` keeps its value and `cmdValid` stays low.
- R2: Bit 0 of a frame is the flag (1 = selection, 0 = command). Bits 1 to 4 are the ID or code, MSB first. Bits 5 to 36 are the received checksum, MSB first.
- R3: The checksum uses polynomial 0x04C11DB7 and starts from all ones. It takes one bit per step, MSB first, with feedback = top bit XOR input bit, and has no reflection or final inversion. It is computed over bits 0 to 4 of the frame.
- R4: A checked frame returns on `tdo` 37 zero bits, then the 4 status bits MSB first, then a 32-bit checksum over those 4 status bits only, starting from all ones. The shift cycle that presents frame bit k also presents response bit k.
- R5: Status encoding: bit 3 = checksum mismatch, bit 2 = target missing, bit 1 = bus-access error, bit 0 = 0.
- R6: Target IDs 0 (system bus), 1 (CPU0) and 2 (CPU1) are valid. A good selection frame with a valid ID loads that value into `selModule` at the update step. Any other ID sets status bit 2 and leaves `selModule` unchanged.
- R7: On a checksum mismatch only bit 3 (plus any pending bus error) is reported, and the frame changes neither the selection nor the command strobe.
- R8: A good command frame with code 0 to 4 raises `cmdValid` for exactly one cycle after the update step, with `cmdCode` holding the code.
- R9: A command frame with a code above 4 stops after its first 5 bits: no check is made, `tdo` stays 0 for the whole frame and no strobe is issued.
- R10: A `busErr` pulse is held. It appears as status bit 1 in the next checked frame's response and is cleared by that report.
- R11: Reset (`rstN` low) sets `selModule` to 3 (none), `cmdValid` to 0 and `tdo` to 0.
- R12: If the update step comes before all 37 header and checksum bits have been shifted in, the frame has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rstN | input | 1 | Asynchronous active-low test-logic reset |
| irValue | input | IR_W | Current instruction register value |
| captureDr | input | 1 | Capture step of the data register scan |
| shiftDr | input | 1 | Shift step, one bit per clock |
| updateDr | input | 1 | Update step that commits the frame |
| tdi | input | 1 | Serial data in |
| busErr | input | 1 | Bus-access error pulse from the access logic |
| tdo | output | 1 | Serial response out |
| selModule | output | SEL_W | Selected target: 0 bus, 1 CPU0, 2 CPU1, 3 none |
| cmdValid | output | 1 | One-cycle command dispatch strobe |
| cmdCode | output | ID_W | Dispatched command code |

## Verification
The bench builds the block with its defaults: a 4-bit instruction register with debug code 8, 4-bit IDs and a 32-bit checksum. This gives the full 73-bit scan and lets every status pattern appear, including a held bus error combined with a good or a bad frame. Frames are also cut short and sent under a foreign instruction, which reaches the cases where the update step must do nothing. An unknown command code tests that the rest of the frame is treated as silent.

// File: rtl/dbg_frame_pkg.sv
package dbg_frame_pkg;
  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam int STAT_W = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic crcInit;
    logic crcStep;
    logic rxStep;
    logic decide;
    logic txStep;
    logic commit;
  } dpStrobe_t;

  function automatic logic [CRC_W-1:0] crcBit(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/dbg_frame_ctrl.sv
module dbg_frame_ctrl
  import dbg_frame_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int CNT_W = 7,
  parameter int HDR_BITS = 5,
  parameter int CHECK_BIT = 36,
  parameter int RESP_END = 73,
  parameter int MAX_CMD = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic             captureDr,
  input  logic             shiftDr,
  input  logic             updateDr,
  input  logic             tdi,
  input  logic             frameGood,
  input  logic             txMsb,
  output dpStrobe_t        strobe,
  output logic             isSelect,
  output logic [ID_W-1:0]  code,
  output logic [CNT_W-1:0] bitCnt,
  output logic             tdo,
  output logic             cmdValid,
  output logic [ID_W-1:0]  cmdCode
);
  localparam logic [CNT_W-1:0] HDR_C   = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] CHECK_C = CNT_W'(CHECK_BIT);
  localparam logic [CNT_W-1:0] START_C = CNT_W'(CHECK_BIT + 1);
  localparam logic [CNT_W-1:0] END_C   = CNT_W'(RESP_END);
  localparam logic [ID_W-1:0]  MAXC_C  = ID_W'(MAX_CMD);

  logic aborted;
  logic responding;
  logic inShift;
  logic [ID_W-1:0] nextCode;
  logic inResp;

  assign inShift  = en & shiftDr;
  assign nextCode = {code[ID_W-2:0], tdi};
  assign inResp   = responding && (bitCnt >= START_C) && (bitCnt < END_C);

  always_comb begin
    strobe.crcInit = en & captureDr;
    strobe.crcStep = inShift && (bitCnt < HDR_C);
    strobe.rxStep  = inShift && (bitCnt >= HDR_C) && (bitCnt <= CHECK_C);
    strobe.decide  = inShift && (bitCnt == CHECK_C) && !aborted;
    strobe.txStep  = inShift && inResp;
    strobe.commit  = en && updateDr && responding;
  end

  assign tdo = en && inResp && txMsb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt     <= '0;
      isSelect   <= 1'b0;
      code       <= '0;
      aborted    <= 1'b0;
      responding <= 1'b0;
      cmdValid   <= 1'b0;
      cmdCode    <= '0;
    end else begin
      cmdValid <= strobe.commit && !isSelect && frameGood;
      if (strobe.commit) begin
        cmdCode    <= code;
        responding <= 1'b0;
      end
      if (strobe.crcInit) begin
        bitCnt     <= '0;
        isSelect   <= 1'b0;
        code       <= '0;
        aborted    <= 1'b0;
        responding <= 1'b0;
      end else if (inShift) begin
        if (bitCnt < END_C) bitCnt <= bitCnt + 1'b1;
        if (bitCnt == '0) isSelect <= tdi;
        if ((bitCnt != '0) && (bitCnt < HDR_C)) code <= nextCode;
        if ((bitCnt == HDR_C - 1'b1) && !isSelect && (nextCode > MAXC_C)) aborted <= 1'b1;
        if (strobe.decide) responding <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbg_frame_datapath.sv
module dbg_frame_datapath
  import dbg_frame_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int SEL_W = 2,
  parameter int NUM_TARGETS = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic             tdi,
  input  logic             isSelect,
  input  logic [ID_W-1:0]  code,
  input  logic             busErr,
  output logic             frameGood,
  output logic             txMsb,
  output logic [SEL_W-1:0] selModule
);
  localparam int TX_W = STAT_W + CRC_W;
  localparam logic [ID_W-1:0] LAST_ID = ID_W'(NUM_TARGETS - 1);

  logic [CRC_W-1:0]  crcRun;
  logic [CRC_W-1:0]  rxCrc;
  logic [TX_W-1:0]   txReg;
  logic              busSticky;
  logic [CRC_W-1:0]  rxFull;
  logic              crcMatch;
  logic              idValid;
  logic [STAT_W-1:0] status;
  logic [CRC_W-1:0]  respCrc;

  assign rxFull   = {rxCrc[CRC_W-2:0], tdi};
  assign crcMatch = (rxFull == crcRun);
  assign idValid  = (code <= LAST_ID);
  assign status   = {~crcMatch, crcMatch & isSelect & ~idValid, busSticky, 1'b0};
  assign txMsb    = txReg[TX_W-1];

  always_comb begin
    respCrc = '1;
    for (int i = STAT_W - 1; i >= 0; i--) respCrc = crcBit(respCrc, status[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcRun    <= '1;
      rxCrc     <= '0;
      txReg     <= '0;
      frameGood <= 1'b0;
      busSticky <= 1'b0;
      selModule <= '1;
    end else begin
      if (strobe.decide) busSticky <= busErr;
      else               busSticky <= busSticky | busErr;

      if (strobe.crcInit) begin
        crcRun    <= '1;
        rxCrc     <= '0;
        frameGood <= 1'b0;
      end else begin
        if (strobe.crcStep) crcRun <= crcBit(crcRun, tdi);
        if (strobe.rxStep)  rxCrc  <= rxFull;
      end

      if (strobe.decide) begin
        txReg     <= {status, respCrc};
        frameGood <= crcMatch & (~isSelect | idValid);
      end else if (strobe.txStep) begin
        txReg <= {txReg[TX_W-2:0], 1'b0};
      end

      if (strobe.commit && isSelect && frameGood) selModule <= code[SEL_W-1:0];
    end
  end
endmodule

// File: rtl/dbg_frame_decoder.sv
module dbg_frame_decoder
  import dbg_frame_pkg::*;
#(
  parameter int IR_W = 4,
  parameter logic [IR_W-1:0] DEBUG_IR = 4'b1000,
  parameter int ID_W = 4,
  parameter int SEL_W = 2,
  parameter int NUM_TARGETS = 3,
  parameter int MAX_CMD = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IR_W-1:0]  irValue,
  input  logic             captureDr,
  input  logic             shiftDr,
  input  logic             updateDr,
  input  logic             tdi,
  input  logic             busErr,
  output logic             tdo,
  output logic [SEL_W-1:0] selModule,
  output logic             cmdValid,
  output logic [ID_W-1:0]  cmdCode
);
  localparam int HDR_BITS  = 1 + ID_W;
  localparam int CHECK_BIT = HDR_BITS + CRC_W - 1;
  localparam int RESP_END  = CHECK_BIT + 1 + STAT_W + CRC_W;
  localparam int CNT_W     = $clog2(RESP_END + 1);

  dpStrobe_t        strobe;
  logic             en;
  logic             isSelect;
  logic [ID_W-1:0]  code;
  logic [CNT_W-1:0] bitCnt;
  logic             frameGood;
  logic             txMsb;

  assign en = (irValue == DEBUG_IR);

  dbg_frame_ctrl #(
    .ID_W(ID_W), .CNT_W(CNT_W), .HDR_BITS(HDR_BITS),
    .CHECK_BIT(CHECK_BIT), .RESP_END(RESP_END), .MAX_CMD(MAX_CMD)
  ) ctrl (
    .clk(clk), .rstN(rstN), .en(en), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .tdi(tdi), .frameGood(frameGood), .txMsb(txMsb),
    .strobe(strobe), .isSelect(isSelect), .code(code), .bitCnt(bitCnt),
    .tdo(tdo), .cmdValid(cmdValid), .cmdCode(cmdCode)
  );

  dbg_frame_datapath #(
    .ID_W(ID_W), .SEL_W(SEL_W), .NUM_TARGETS(NUM_TARGETS)
  ) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tdi(tdi), .isSelect(isSelect),
    .code(code), .busErr(busErr), .frameGood(frameGood), .txMsb(txMsb),
    .selModule(selModule)
  );
endmodule

// File: rtl/dbg_frame_decoder_chk.sv
module dbg_frame_decoder_chk #(
  parameter int IR_W = 4,
  parameter logic [IR_W-1:0] DEBUG_IR = 4'b1000,
  parameter int ID_W = 4,
  parameter int SEL_W = 2,
  parameter int CNT_W = 7,
  parameter int RESP_START = 37,
  parameter int MAX_CMD = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [IR_W-1:0]  irValue,
  input logic             shiftDr,
  input logic             updateDr,
  input logic             tdo,
  input logic [SEL_W-1:0] selModule,
  input logic             cmdValid,
  input logic [ID_W-1:0]  cmdCode,
  input logic [CNT_W-1:0] bitCnt
);
  // R1: foreign instruction keeps the serial output quiet
  a_r1_foreign_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (irValue != DEBUG_IR) |-> !tdo);

  // R4: leading part of the response is zero
  a_r4_lead_zero: assert property (@(posedge clk) disable iff (!rstN)
    (shiftDr && (bitCnt < CNT_W'(RESP_START))) |-> !tdo);

  // R6: selection only moves on an update step
  a_r6_sel_on_update: assert property (@(posedge clk) disable iff (!rstN)
    !updateDr |=> $stable(selModule));

  // R8: strobe lasts one cycle
  a_r8_cmd_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R8: strobe follows an update step
  a_r8_cmd_after_update: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $past(updateDr));

  // R9: no dispatched code above the command range
  a_r9_code_range: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdCode <= ID_W'(MAX_CMD)));
endmodule

bind dbg_frame_decoder dbg_frame_decoder_chk #(
  .IR_W(IR_W), .DEBUG_IR(DEBUG_IR), .ID_W(ID_W), .SEL_W(SEL_W),
  .CNT_W(CNT_W), .RESP_START(CHECK_BIT + 1), .MAX_CMD(MAX_CMD)
) chk (
  .clk(clk), .rstN(rstN), .irValue(irValue), .shiftDr(shiftDr),
  .updateDr(updateDr), .tdo(tdo), .selModule(selModule), .cmdValid(cmdValid),
  .cmdCode(cmdCode), .bitCnt(bitCnt)
);

// File: tb/dbg_frame_decoder_test.sv
module dbg_frame_decoder_test;
  localparam int FR = 73;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] irValue = 4'b1000;
  logic captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0, tdi = 1'b0, busErr = 1'b0;
  logic tdo;
  logic [1:0] selModule;
  logic cmdValid;
  logic [3:0] cmdCode;

  int errors = 0;
  int checks = 0;

  logic [FR-1:0] expQ[$];
  string tagQ[$];
  logic [FR-1:0] act;

  always #5 clk = ~clk;

  dbg_frame_decoder uut (
    .clk(clk), .rstN(rstN), .irValue(irValue), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .tdi(tdi), .busErr(busErr),
    .tdo(tdo), .selModule(selModule), .cmdValid(cmdValid), .cmdCode(cmdCode)
  );

  function automatic logic [31:0] crcUpd(input logic [31:0] c, input logic b);
    return {c[30:0], 1'b0} ^ ((c[31] ^ b) ? 32'h04C11DB7 : 32'h0);
  endfunction

  function automatic logic [31:0] crcOf(input logic [4:0] bits, input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = n - 1; i >= 0; i--) c = crcUpd(c, bits[i]);
    return c;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [FR-1:0] a, input logic [FR-1:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, a, e);
    end
  endtask

  // Monitor: gathers tdo during shift, compares at update
  always @(negedge clk) begin
    #1;
    if (captureDr) act = '0;
    if (shiftDr) act = {act[FR-2:0], tdo};
    if (updateDr && expQ.size() > 0) begin
      logic [FR-1:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(act === e, t, act, e);
    end
  end

  // Driver: builds the frame, pushes the expected response, shifts it
  task automatic runFrame(input logic flag, input logic [3:0] id, input logic badCrc,
                          input logic respond, input logic [3:0] expStat,
                          input int nShift, input string tag);
    logic [31:0] c;
    logic [FR-1:0] frm;
    logic [FR-1:0] e;
    c = crcOf({flag, id}, 5);
    if (badCrc) c = c ^ 32'h1;
    frm = {flag, id, c, 36'b0};
    e = respond ? {37'b0, expStat, crcOf({1'b0, expStat}, 4)} : '0;
    if (nShift < FR) e = '0;
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk) captureDr = 1'b1;
    @(negedge clk) captureDr = 1'b0;
    for (int i = 0; i < nShift; i++) begin
      shiftDr = 1'b1;
      tdi = frm[FR-1-i];
      @(negedge clk);
    end
    shiftDr = 1'b0;
    updateDr = 1'b1;
    @(negedge clk) updateDr = 1'b0;
    #2;
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check(selModule == 2'd3 && !tdo && !cmdValid, "R11 reset state", {selModule, tdo, cmdValid}, {2'd3, 2'b0});
    @(negedge clk) rstN = 1'b1;

    runFrame(1, 4'd1, 0, 1, 4'h0, FR, "R2 R3 R4 select CPU0 response");
    check(selModule == 2'd1, "R6 select CPU0", selModule, 1);
    runFrame(1, 4'd2, 0, 1, 4'h0, FR, "R4 select CPU1 response");
    check(selModule == 2'd2, "R6 select CPU1", selModule, 2);
    runFrame(1, 4'd5, 0, 1, 4'h4, FR, "R5 missing target status");
    check(selModule == 2'd2, "R6 missing target keeps selection", selModule, 2);
    runFrame(1, 4'd0, 1, 1, 4'h8, FR, "R7 bad checksum status");
    check(selModule == 2'd2, "R7 bad checksum keeps selection", selModule, 2);

    @(negedge clk) busErr = 1'b1;
    @(negedge clk) busErr = 1'b0;
    runFrame(1, 4'd0, 0, 1, 4'h2, FR, "R10 bus error reported");
    check(selModule == 2'd0, "R6 select bus", selModule, 0);
    runFrame(1, 4'd1, 0, 1, 4'h0, FR, "R10 bus error cleared");

    runFrame(0, 4'd1, 0, 1, 4'h0, FR, "R8 command 1 response");
    check(cmdValid && cmdCode == 4'd1, "R8 command 1 strobe", {cmdValid, cmdCode}, {1'b1, 4'd1});
    @(negedge clk) #2;
    check(!cmdValid, "R8 strobe one cycle", cmdValid, 0);
    runFrame(0, 4'd4, 0, 1, 4'h0, FR, "R8 command 4 response");
    check(cmdValid && cmdCode == 4'd4, "R8 command 4 strobe", {cmdValid, cmdCode}, {1'b1, 4'd4});
    runFrame(0, 4'd2, 1, 1, 4'h8, FR, "R7 command bad checksum");
    check(!cmdValid, "R7 no strobe on bad checksum", cmdValid, 0);
    runFrame(0, 4'd7, 0, 0, 4'h0, FR, "R9 unknown code silent");
    check(!cmdValid, "R9 no strobe for unknown code", cmdValid, 0);

    runFrame(1, 4'd2, 0, 0, 4'h0, 20, "R12 short frame silent");
    check(selModule == 2'd1, "R12 short frame keeps selection", selModule, 1);

    irValue = 4'b0011;
    runFrame(1, 4'd0, 0, 0, 4'h0, FR, "R1 foreign instruction silent");
    check(selModule == 2'd1, "R1 foreign instruction keeps selection", selModule, 1);
    runFrame(0, 4'd0, 0, 0, 4'h0, FR, "R1 foreign instruction command");
    check(!cmdValid, "R1 foreign instruction no strobe", cmdValid, 0);
    irValue = 4'b1000;

    @(negedge clk) rstN = 1'b0;
    #2;
    check(selModule == 2'd3, "R11 reset clears selection", selModule, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule